// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Sequencer

This block follows a USB control transfer on endpoint 0 through its stages when firmware, not hardware, interprets the request. A packet engine feeds it decoded token events (SETUP, IN, OUT), along with a flag that says whether the data packet after the token arrived intact or corrupted, and a strobe for each host ACK received after the device has transmitted. From these events and the state the processor has set up, the block decides how the device responds to each transaction. The response is an ACK, NAK or STALL handshake, a data packet taken from the endpoint FIFO, or a zero-length packet.

On the processor side there are two strobes. One arms the FIFO ("data ready", or "ready to accept") for exactly one transaction. The other requests a stall. Once set, the stall persists through every remaining transaction of the transfer and is released only by the next intact SETUP. The processor can read the current stage, the stall state and the arm state. It receives a pulse for each accepted SETUP, a pulse when the transaction direction turns around (the status stage begins), and a pulse when the transfer finishes.

The direction of the data stage comes from the packet engine with each SETUP (the top bit of the request type). Any later token that runs against that direction marks the start of the status stage.

Top module: `ep0_ctl_seq`

## Requirements
- R1: After reset, stage reads 0 (idle), stalled and fifo_armed are 0, and hs_valid, tx_data, tx_zlp, setup_irq, xfer_done and status_start are all 0.
- R2: An intact SETUP produces, one cycle later, a handshake with hs_code 0 (ACK), a setup_irq pulse and stage 1 (setup). It clears the stall and the FIFO arm. This happens even while stalled, and the SETUP wins over a same-cycle stall or arm strobe.
- R3: A SETUP or OUT whose data packet is corrupted (pkt_bad) produces no handshake and no setup_irq, and it leaves stage, stall and arm unchanged.
- R4: After a stall request, every IN and every intact OUT is answered with hs_code 2 (STALL) until the next intact SETUP.
- R5: During a transfer, an IN or intact OUT that arrives while the FIFO is not armed is answered with hs_code 1 (NAK), and the state does not advance.
- R6: In a read transfer (direction bit 1), an armed IN during the setup or data stage makes tx_data pulse with no handshake and moves the stage to 2 (data). The next host ACK clears the arm.
- R7: In a write transfer (direction bit 0), an armed intact OUT during the setup or data stage is answered with ACK, clears the arm and moves the stage to 2.
- R8: The first IN in a write transfer, or the first intact OUT in a read transfer, pulses status_start and moves the stage to 3 (status), unless the block is stalled. This holds even when the token is NAKed.
- R9: In the status stage of a write transfer, an armed IN makes tx_zlp pulse. The following host ACK pulses xfer_done, returns the stage to 0 and clears the arm.
- R10: In the status stage of a read transfer, an armed intact OUT is answered with ACK, pulses xfer_done in the same cycle and returns the stage to 0.
- R11: With the default parameter, an IN or intact OUT that arrives while no transfer is open (stage 0) is answered with STALL.
- R12: In the status stage, a token running in the data-stage direction is answered with STALL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | SETUP token event (with its data packet status) |
| tok_in | input | 1 | IN token event |
| tok_out | input | 1 | OUT token event (with its data packet status) |
| pkt_good | input | 1 | Data packet after SETUP/OUT arrived intact |
| pkt_bad | input | 1 | Data packet after SETUP/OUT failed its CRC |
| setup_dir_in | input | 1 | Direction bit of the SETUP request (1 = device to host) |
| host_ack | input | 1 | Host ACK received after a device transmission |
| cpu_stall_req | input | 1 | Processor strobe: stall the rest of the transfer |
| cpu_fifo_arm | input | 1 | Processor strobe: FIFO ready for one transaction |
| hs_valid | output | 1 | Send a handshake this cycle |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| tx_data | output | 1 | Send a data packet from the FIFO |
| tx_zlp | output | 1 | Send a zero-length data packet |
| setup_irq | output | 1 | Pulse: intact SETUP accepted |
| xfer_done | output | 1 | Pulse: status stage finished |
| status_start | output | 1 | Pulse: direction turned, status stage begins |
| stage | output | 2 | 0 idle, 1 setup, 2 data, 3 status |
| stalled | output | 1 | Stall is latched |
| fifo_armed | output | 1 | FIFO is armed for the next transaction |

## Verification
The bench concentrates on the stall latch. It issues mixes of IN, OUT and corrupted packets after a stall request to catch a latch that drops after the first STALL or that a non-SETUP event can clear. It sends SETUPs while stalled and in the same cycle as a stall strobe. A design with the wrong priority would leave the new transfer stalled or withhold the ACK. Corrupted SETUP and OUT packets arrive in every stage, so a design that reacts to them shows up as a stray handshake, a stray interrupt or a stage change. The direction turnaround is exercised both with and without a data stage and while the FIFO is unarmed, which exposes a design that treats a NAKed status token as still belonging to the data stage, or that finishes a write before the host ACKs its zero-length packet.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

   typedef enum logic [1:0] {
      HS_ACK   = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2
   } hs_e;

   typedef enum logic [1:0] {
      STG_IDLE   = 2'd0,
      STG_SETUP  = 2'd1,
      STG_DATA   = 2'd2,
      STG_STATUS = 2'd3
   } stage_e;

endpackage

// File: rtl/ep0_resp_dec.sv
module ep0_resp_dec
   import ep0_seq_pkg::*;
#(
   parameter int unsigned IDLE_NAK = 0
) (
   input  logic   tok_setup,
   input  logic   tok_in,
   input  logic   tok_out,
   input  logic   pkt_good,
   input  logic   pkt_bad,
   input  stage_e stage,
   input  logic   dir_in,
   input  logic   stalled,
   input  logic   fifo_armed,
   output logic   setup_ok,
   output logic   hs_vld,
   output hs_e    hs,
   output logic   send_data,
   output logic   send_zlp,
   output logic   out_taken,
   output logic   in_sent,
   output logic   stat_enter
);

   hs_e  idle_hs;
   logic ev_out, ev_in, open_xfer, turn, in_status, wrong_dir;

   generate
      if (IDLE_NAK != 0) begin : g_idle_nak
         assign idle_hs = HS_NAK;
      end else begin : g_idle_stall
         assign idle_hs = HS_STALL;
      end
   endgenerate

   always_comb begin
      setup_ok   = tok_setup & pkt_good & ~pkt_bad;
      ev_out     = tok_out & pkt_good & ~pkt_bad & ~tok_setup;
      ev_in      = tok_in & ~tok_setup & ~tok_out;
      open_xfer  = (stage == STG_SETUP) || (stage == STG_DATA);
      turn       = open_xfer && ((ev_in && !dir_in) || (ev_out && dir_in));
      in_status  = turn || (stage == STG_STATUS);
      wrong_dir  = (stage == STG_STATUS) &&
                   ((ev_in && dir_in) || (ev_out && !dir_in));

      hs_vld     = 1'b0;
      hs         = HS_ACK;
      send_data  = 1'b0;
      send_zlp   = 1'b0;
      out_taken  = 1'b0;
      in_sent    = 1'b0;
      stat_enter = 1'b0;

      if (setup_ok) begin
         hs_vld = 1'b1;
         hs     = HS_ACK;
      end else if (ev_in || ev_out) begin
         stat_enter = turn && !stalled;
         if (stage == STG_IDLE) begin
            hs_vld = 1'b1;
            hs     = idle_hs;
         end else if (stalled || wrong_dir) begin
            hs_vld = 1'b1;
            hs     = HS_STALL;
         end else if (!fifo_armed) begin
            hs_vld = 1'b1;
            hs     = HS_NAK;
         end else if (ev_out) begin
            hs_vld    = 1'b1;
            hs        = HS_ACK;
            out_taken = 1'b1;
         end else begin
            in_sent   = 1'b1;
            send_data = !in_status;
            send_zlp  = in_status;
         end
      end
   end

endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
   import ep0_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   setup_ok,
   input  logic   setup_dir_in,
   input  logic   hs_vld,
   input  logic   send_data,
   input  logic   send_zlp,
   input  logic   out_taken,
   input  logic   in_sent,
   input  logic   stat_enter,
   input  logic   host_ack,
   output stage_e stage,
   output logic   dir_in,
   output logic   in_acked,
   output logic   xfer_done,
   output logic   status_start
);

   logic pend, pend_zlp, any_tok;

   assign any_tok  = hs_vld | in_sent;
   assign in_acked = host_ack & pend & ~any_tok & ~setup_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage        <= STG_IDLE;
         dir_in       <= 1'b0;
         pend         <= 1'b0;
         pend_zlp     <= 1'b0;
         xfer_done    <= 1'b0;
         status_start <= 1'b0;
      end else begin
         xfer_done    <= 1'b0;
         status_start <= 1'b0;
         if (setup_ok) begin
            stage    <= STG_SETUP;
            dir_in   <= setup_dir_in;
            pend     <= 1'b0;
            pend_zlp <= 1'b0;
         end else begin
            if (stat_enter) begin
               stage        <= STG_STATUS;
               status_start <= 1'b1;
            end
            if (any_tok) begin
               pend     <= in_sent;
               pend_zlp <= send_zlp;
               if (send_data) stage <= STG_DATA;
               if (out_taken) begin
                  if (stage == STG_STATUS || stat_enter) begin
                     stage     <= STG_IDLE;
                     xfer_done <= 1'b1;
                  end else begin
                     stage <= STG_DATA;
                  end
               end
            end else if (in_acked) begin
               pend <= 1'b0;
               if (pend_zlp) begin
                  stage     <= STG_IDLE;
                  xfer_done <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/ep0_cpu_flags.sv
module ep0_cpu_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic setup_ok,
   input  logic cpu_stall_req,
   input  logic cpu_fifo_arm,
   input  logic out_taken,
   input  logic in_acked,
   output logic stalled,
   output logic fifo_armed
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stalled    <= 1'b0;
         fifo_armed <= 1'b0;
      end else if (setup_ok) begin
         stalled    <= 1'b0;
         fifo_armed <= 1'b0;
      end else begin
         if (cpu_stall_req) stalled <= 1'b1;
         if (cpu_fifo_arm)
            fifo_armed <= 1'b1;
         else if (out_taken || in_acked)
            fifo_armed <= 1'b0;
      end
   end

endmodule

// File: rtl/ep0_ctl_seq.sv
module ep0_ctl_seq
   import ep0_seq_pkg::*;
#(
   parameter int unsigned IDLE_NAK = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_setup,
   input  logic       tok_in,
   input  logic       tok_out,
   input  logic       pkt_good,
   input  logic       pkt_bad,
   input  logic       setup_dir_in,
   input  logic       host_ack,
   input  logic       cpu_stall_req,
   input  logic       cpu_fifo_arm,
   output logic       hs_valid,
   output logic [1:0] hs_code,
   output logic       tx_data,
   output logic       tx_zlp,
   output logic       setup_irq,
   output logic       xfer_done,
   output logic       status_start,
   output logic [1:0] stage,
   output logic       stalled,
   output logic       fifo_armed
);

   initial begin
      if (IDLE_NAK > 1)
         $error("IDLE_NAK must be 0 or 1");
   end

   stage_e cur_stage;
   logic   dir_in;
   logic   setup_ok, hs_vld, send_data, send_zlp, out_taken, in_sent, stat_enter;
   logic   in_acked;
   hs_e    hs;

   ep0_resp_dec #(.IDLE_NAK(IDLE_NAK)) u_dec (
      .tok_setup  (tok_setup),
      .tok_in     (tok_in),
      .tok_out    (tok_out),
      .pkt_good   (pkt_good),
      .pkt_bad    (pkt_bad),
      .stage      (cur_stage),
      .dir_in     (dir_in),
      .stalled    (stalled),
      .fifo_armed (fifo_armed),
      .setup_ok   (setup_ok),
      .hs_vld     (hs_vld),
      .hs         (hs),
      .send_data  (send_data),
      .send_zlp   (send_zlp),
      .out_taken  (out_taken),
      .in_sent    (in_sent),
      .stat_enter (stat_enter)
   );

   ep0_stage_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .setup_ok     (setup_ok),
      .setup_dir_in (setup_dir_in),
      .hs_vld       (hs_vld),
      .send_data    (send_data),
      .send_zlp     (send_zlp),
      .out_taken    (out_taken),
      .in_sent      (in_sent),
      .stat_enter   (stat_enter),
      .host_ack     (host_ack),
      .stage        (cur_stage),
      .dir_in       (dir_in),
      .in_acked     (in_acked),
      .xfer_done    (xfer_done),
      .status_start (status_start)
   );

   ep0_cpu_flags u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .setup_ok      (setup_ok),
      .cpu_stall_req (cpu_stall_req),
      .cpu_fifo_arm  (cpu_fifo_arm),
      .out_taken     (out_taken),
      .in_acked      (in_acked),
      .stalled       (stalled),
      .fifo_armed    (fifo_armed)
   );

   assign stage = cur_stage;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_valid  <= 1'b0;
         hs_code   <= HS_ACK;
         tx_data   <= 1'b0;
         tx_zlp    <= 1'b0;
         setup_irq <= 1'b0;
      end else begin
         hs_valid  <= hs_vld;
         hs_code   <= hs;
         tx_data   <= send_data;
         tx_zlp    <= send_zlp;
         setup_irq <= setup_ok;
      end
   end

   // R2
   setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_setup && pkt_good && !pkt_bad) |=>
         (hs_valid && hs_code == HS_ACK && setup_irq && stage == STG_SETUP && !stalled));

   // R3
   bad_pkt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tok_setup || tok_out) && pkt_bad && !pkt_good && !tok_in) |=>
         (!hs_valid && !setup_irq && $stable(stage)));

   // R4
   stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && !tok_setup && ((tok_in && !tok_out) || (tok_out && pkt_good && !pkt_bad))) |=>
         (hs_valid && hs_code == HS_STALL));

   // R5
   unarmed_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stalled && !fifo_armed && !tok_setup &&
       (stage == STG_SETUP || stage == STG_DATA) &&
       ((tok_in && !tok_out) || (tok_out && pkt_good && !pkt_bad))) |=>
         (hs_valid && hs_code == HS_NAK));

   // R8
   status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_start |-> (stage == STG_STATUS || xfer_done));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (stage == STG_IDLE));

   // R6
   tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((tx_data || tx_zlp) && hs_valid) && !(tx_data && tx_zlp));

endmodule

// File: tb/ep0_ctl_seq_tb.sv
module ep0_ctl_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tok_setup, tok_in, tok_out, pkt_good, pkt_bad, setup_dir_in;
   logic       host_ack, cpu_stall_req, cpu_fifo_arm;
   logic       hs_valid, tx_data, tx_zlp, setup_irq, xfer_done, status_start;
   logic       stalled, fifo_armed;
   logic [1:0] hs_code, stage;

   int n_run  = 0;
   int n_fail = 0;

   // model state
   int m_stage, m_dir, m_stall, m_arm, m_pend, m_pzlp;

   always #5 clk = ~clk;

   ep0_ctl_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .tok_setup(tok_setup), .tok_in(tok_in), .tok_out(tok_out),
      .pkt_good(pkt_good), .pkt_bad(pkt_bad), .setup_dir_in(setup_dir_in),
      .host_ack(host_ack), .cpu_stall_req(cpu_stall_req), .cpu_fifo_arm(cpu_fifo_arm),
      .hs_valid(hs_valid), .hs_code(hs_code), .tx_data(tx_data), .tx_zlp(tx_zlp),
      .setup_irq(setup_irq), .xfer_done(xfer_done), .status_start(status_start),
      .stage(stage), .stalled(stalled), .fifo_armed(fifo_armed)
   );

   function automatic logic [13:0] pack_out();
      return {hs_valid, (hs_valid ? hs_code : 2'd0), tx_data, tx_zlp, setup_irq,
              xfer_done, status_start, stage, stalled, fifo_armed, 2'b00};
   endfunction

   task automatic clear_in();
      tok_setup = 0; tok_in = 0; tok_out = 0; pkt_good = 0; pkt_bad = 0;
      setup_dir_in = 0; host_ack = 0; cpu_stall_req = 0; cpu_fifo_arm = 0;
   endtask

   // kind: 0 idle, 1 SETUP, 2 IN, 3 OUT, 4 host ACK
   task automatic ev(input int kind, input bit good, input bit sdir,
                     input bit cst, input bit carm);
      bit e_vld, e_txd, e_txz, e_irq, e_done, e_ss, consume;
      int e_hs, n_stage, n_dir, n_stall, n_arm, n_pend, n_pzlp;
      bit setup_ok, out_ok, in_ev, open_x, turn, stat, wrong;
      string tag;
      logic [13:0] exp_v, act_v;
      clear_in();
      tok_setup = (kind == 1); tok_in = (kind == 2); tok_out = (kind == 3);
      host_ack = (kind == 4);
      if (kind == 1 || kind == 3) begin pkt_good = good; pkt_bad = !good; end
      setup_dir_in = sdir; cpu_stall_req = cst; cpu_fifo_arm = carm;

      e_vld = 0; e_hs = 0; e_txd = 0; e_txz = 0; e_irq = 0; e_done = 0; e_ss = 0;
      consume = 0; tag = "R1";
      n_stage = m_stage; n_dir = m_dir; n_stall = m_stall; n_arm = m_arm;
      n_pend = m_pend; n_pzlp = m_pzlp;
      setup_ok = (kind == 1) && good;
      out_ok   = (kind == 3) && good;
      in_ev    = (kind == 2);
      open_x   = (m_stage == 1 || m_stage == 2);
      turn     = open_x && ((in_ev && m_dir == 0) || (out_ok && m_dir == 1));
      stat     = turn || m_stage == 3;
      wrong    = (m_stage == 3) && ((in_ev && m_dir == 1) || (out_ok && m_dir == 0));
      if (setup_ok) begin
         e_vld = 1; e_hs = 0; e_irq = 1; tag = "R2";
         n_stage = 1; n_dir = sdir; n_pend = 0; n_pzlp = 0; n_stall = 0; n_arm = 0;
      end else begin
         if ((kind == 1 || kind == 3) && !good) tag = "R3";
         if (in_ev || out_ok) begin
            if (turn && m_stall == 0) begin e_ss = 1; n_stage = 3; tag = "R8"; end
            if (m_stage == 0) begin e_vld = 1; e_hs = 2; tag = "R11"; end
            else if (m_stall != 0) begin e_vld = 1; e_hs = 2; tag = "R4"; end
            else if (wrong) begin e_vld = 1; e_hs = 2; tag = "R12"; end
            else if (m_arm == 0) begin e_vld = 1; e_hs = 1; tag = "R5"; end
            else if (out_ok) begin
               e_vld = 1; e_hs = 0; consume = 1;
               if (stat) begin e_done = 1; n_stage = 0; tag = "R10"; end
               else begin n_stage = 2; tag = "R7"; end
            end else begin
               e_txd = !stat; e_txz = stat;
               if (stat) tag = "R9"; else begin n_stage = 2; tag = "R6"; end
            end
            n_pend = (e_txd || e_txz); n_pzlp = e_txz;
         end else if (kind == 4 && m_pend != 0) begin
            n_pend = 0; consume = 1;
            if (m_pzlp != 0) begin e_done = 1; n_stage = 0; tag = "R9"; end
            else tag = "R6";
         end
         if (cst) n_stall = 1;
         if (carm) n_arm = 1; else if (consume) n_arm = 0;
      end
      m_stage = n_stage; m_dir = n_dir; m_stall = n_stall; m_arm = n_arm;
      m_pend = n_pend; m_pzlp = n_pzlp;
      exp_v = {e_vld, e_hs[1:0], e_txd, e_txz, e_irq, e_done, e_ss,
               m_stage[1:0], m_stall[0], m_arm[0], 2'b00};

      @(negedge clk);
      act_v = pack_out();
      n_run++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s kind=%0d actual=%b expected=%b", tag, kind, act_v, exp_v);
      end
      clear_in();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0E0));
      clear_in();
      rst_n = 0;
      m_stage = 0; m_dir = 0; m_stall = 0; m_arm = 0; m_pend = 0; m_pzlp = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      n_run++;
      if (pack_out() !== 14'd0) begin
         n_fail++;
         $display("FAIL R1 actual=%b expected=%b", pack_out(), 14'd0);
      end
      // R11 token with no transfer open
      ev(2, 1, 0, 0, 0);
      ev(3, 1, 0, 0, 0);
      // R3 corrupted setup
      ev(1, 0, 1, 0, 0);
      // control read: R2, R5, R6, R8, R10
      ev(1, 1, 1, 0, 0);
      ev(2, 1, 0, 0, 0);            // R5 NAK unarmed
      ev(0, 1, 0, 0, 1);            // arm
      ev(2, 1, 0, 0, 0);            // R6 data
      ev(4, 1, 0, 0, 0);            // R6 ack clears arm
      ev(3, 0, 0, 0, 0);            // R3 corrupt OUT
      ev(3, 1, 0, 0, 0);            // R8 turn, NAK
      ev(2, 1, 0, 0, 0);            // R12 wrong direction in status
      ev(0, 1, 0, 0, 1);
      ev(3, 1, 0, 0, 0);            // R10 done
      // control write with data: R7, R9
      ev(1, 1, 0, 0, 1);            // R2 setup wins over arm
      ev(0, 1, 0, 0, 1);
      ev(3, 1, 0, 0, 0);            // R7
      ev(0, 1, 0, 0, 1);
      ev(2, 1, 0, 0, 0);            // R8 + R9 zlp
      ev(4, 1, 0, 0, 0);            // R9 done
      // write without data stage, then stall: R4
      ev(1, 1, 0, 0, 0);
      ev(0, 1, 0, 1, 1);            // stall request
      ev(2, 1, 0, 0, 0);            // R4
      ev(3, 1, 0, 0, 0);            // R4
      ev(3, 0, 0, 0, 0);            // R3 while stalled
      ev(2, 1, 0, 0, 0);            // R4 still
      ev(1, 1, 1, 1, 0);            // R2 setup beats same-cycle stall
      ev(0, 1, 0, 0, 1);
      ev(2, 1, 0, 0, 0);            // R6
      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int k;
         k = $urandom_range(0, 4);
         ev(k, ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
            ($urandom_range(0, 19) == 0), ($urandom_range(0, 2) == 0));
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule